// File: doc/BRIEF.md
# Serial-Loaded Display Segment Driver

This block drives the segment lines of a multi-digit display from a single serial stream. Bits enter a 34-stage shift chain on each rising clock edge. When the load input is high at an edge, the chain's upper 33 stages are copied into a 33-bit hold latch, and the chain is zeroed in the same edge. A fixed permutation then routes each latch bit to one segment line. A brightness gate input forces every segment line low while it is low. The caller can pulse this input to dim the display, or hold it high for full duty.

The end of the chain is visible on a serial output. That output can feed the next device in a cascade. It can also be looped back into the load input. In that mode each frame opens with a 1 start bit, and the device loads itself once that start bit reaches the end of the chain. Because the clear that follows a load leaves only zeros behind, the same frame never triggers a second load.

Top module: `seg_serial_driver`

## Requirements
- R1: While `rst_ni` is low, every stage and every latch bit is 0, so `seg_o` and `sdata_o` are 0.
- R2: At a rising edge with `load_i` low, stage 33 takes `sdata_i` and stage s (s < 33) takes the old stage s+1. After 34 such edges, the first bit clocked in sits in stage 0 and the last bit in stage 33.
- R3: `sdata_o` always equals stage 0 of the chain.
- R4: At a rising edge with `load_i` high, latch bit j takes stage j+1, for j = 0..32. Stage 0 (the start-bit position) is never latched.
- R5: That same edge sets all 34 stages to 0, and `sdata_i` is ignored for that edge.
- R6: The latch keeps its value at every edge where `load_i` is low.
- R7: Segment output k carries latch bit (k*ROUTE_MUL + ROUTE_OFS) mod 33. The defaults are ROUTE_MUL = 7 and ROUTE_OFS = 0. ROUTE_MUL must be coprime with 33 so that the routing is a permutation.
- R8: When `blank_i` is low, every `seg_o` bit is 0 and the latch is unchanged. When `blank_i` is high, the routed latch is driven without change.
- R9: With `sdata_o` tied to `load_i`, a frame consists of a 1 start bit followed by 33 data bits, and data bit i lands in latch bit i. The latch updates at the edge after the 34th frame edge. The serial bit presented in that cycle is discarded.
- R10: After a self-load, any run of zero input bits causes no further load, so the segment pattern stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial shift clock, rising-edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sdata_i | input | 1 | Serial data in |
| load_i | input | 1 | Latch transfer and chain clear, active high |
| blank_i | input | 1 | Brightness gate; low forces all segments off |
| seg_o | output | 33 | Routed segment enables |
| sdata_o | output | 1 | End of chain, for cascading or self-load |

## Verification
The hardest situation to reach is self-load with the output looped back. Here the load is produced by the design itself, so a wrong clear or an off-by-one stage count shows up only as a second load, or as a shifted pattern, several frames later. The bench wires `sdata_o` back to `load_i` through a mux and sends back-to-back start-bit frames of random data with random idle gaps. It then sends long zero runs that would expose a lingering start bit. Direct-load frames of random length, including frames longer than the chain, test the stage numbering against the permutation. Random toggling of the brightness gate runs throughout.

// File: rtl/segdrv_pkg.sv
package segdrv_pkg;
  localparam int unsigned SEG_N = 33;

  function automatic int unsigned gcd_f(input int unsigned a, input int unsigned b);
    int unsigned x = a;
    int unsigned y = b;
    for (int i = 0; i < 64; i++) begin
      if (y != 0) begin
        int unsigned t = x % y;
        x = y;
        y = t;
      end
    end
    return x;
  endfunction

  function automatic int unsigned route_idx(input int unsigned k, input int unsigned mul,
                                            input int unsigned ofs, input int unsigned n);
    return (k * mul + ofs) % n;
  endfunction
endpackage

// File: rtl/seg_shift.sv
module seg_shift #(
  parameter int unsigned N_STG = 34
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sdata_i,
  input  logic             load_i,
  output logic [N_STG-1:0] stg_o
);
  logic [N_STG-1:0] sr_q;

  // new bit enters the top, chain end is stage 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (load_i) sr_q <= '0;
    else             sr_q <= {sdata_i, sr_q[N_STG-1:1]};
  end

  assign stg_o = sr_q;

  // R2
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> sr_q[N_STG-1] == $past(sdata_i));
  // R2
  shift_mv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> sr_q[N_STG-2:0] == $past(sr_q[N_STG-1:1]));
  // R5
  sr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> sr_q == '0);
endmodule

// File: rtl/seg_latch_route.sv
module seg_latch_route
  import segdrv_pkg::*;
#(
  parameter int unsigned N_SEG     = 33,
  parameter int unsigned ROUTE_MUL = 7,
  parameter int unsigned ROUTE_OFS = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [N_SEG-1:0] data_i,
  input  logic             blank_i,
  output logic [N_SEG-1:0] seg_o
);
  logic [N_SEG-1:0] lat_q;
  logic [N_SEG-1:0] routed;

  if (gcd_f(ROUTE_MUL % N_SEG, N_SEG) != 1) begin : g_bad_route
    $error("ROUTE_MUL must be coprime with N_SEG");
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lat_q <= '0;
    else if (load_i) lat_q <= data_i;
  end

  for (genvar k = 0; k < N_SEG; k++) begin : g_route
    assign routed[k] = lat_q[route_idx(k, ROUTE_MUL, ROUTE_OFS, N_SEG)];
  end

  assign seg_o = blank_i ? routed : '0;

  // R6
  lat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(lat_q));
  // R4
  lat_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> lat_q == $past(data_i));
  // R7
  route_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |-> $countones(seg_o) == $countones(lat_q));
endmodule

// File: rtl/seg_serial_driver.sv
module seg_serial_driver
  import segdrv_pkg::*;
#(
  parameter int unsigned N_SEG     = SEG_N,
  parameter int unsigned ROUTE_MUL = 7,
  parameter int unsigned ROUTE_OFS = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sdata_i,
  input  logic             load_i,
  input  logic             blank_i,
  output logic [N_SEG-1:0] seg_o,
  output logic             sdata_o
);
  localparam int unsigned N_STG = N_SEG + 1;

  logic [N_STG-1:0] stg;

  seg_shift #(.N_STG(N_STG)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sdata_i(sdata_i),
    .load_i (load_i),
    .stg_o  (stg)
  );

  // stage 0 holds the start bit and is not latched
  seg_latch_route #(
    .N_SEG    (N_SEG),
    .ROUTE_MUL(ROUTE_MUL),
    .ROUTE_OFS(ROUTE_OFS)
  ) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .data_i (stg[N_STG-1:1]),
    .blank_i(blank_i),
    .seg_o  (seg_o)
  );

  assign sdata_o = stg[0];

  // R8
  blank_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_i |-> $countones(seg_o) == 0);
  // R5
  dout_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !sdata_o);
endmodule

// File: tb/tb_seg_serial_driver.sv
`timescale 1ns/1ps
module tb_seg_serial_driver;
  localparam int N = 33;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 1'b0;
  logic load_drv = 1'b0;
  logic blank = 1'b1;
  logic loop = 1'b0;
  logic load;
  logic [N-1:0] seg;
  logic sdout;

  logic [N:0]   ref_sr = '0;
  logic [N-1:0] ref_lat = '0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign load = loop ? sdout : load_drv;

  seg_serial_driver dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .sdata_i(sdata),
    .load_i (load),
    .blank_i(blank),
    .seg_o  (seg),
    .sdata_o(sdout)
  );

  function automatic logic [N-1:0] exp_seg(input logic [N-1:0] lat, input logic bl);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) r[k] = lat[(k * 7) % N];
    return bl ? r : '0;
  endfunction

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic d, input logic ld, input logic bl);
    logic le;
    sdata = d;
    load_drv = ld;
    blank = bl;
    le = loop ? ref_sr[0] : ld;
    @(posedge clk);
    #1;
    if (le) begin
      ref_lat = ref_sr[N:1];
      ref_sr = '0;
    end else begin
      ref_sr = {d, ref_sr[N:1]};
    end
    chk(bl ? "R7" : "R8", seg, exp_seg(ref_lat, bl));
    chk("R3", {{(N-1){1'b0}}, sdout}, {{(N-1){1'b0}}, ref_sr[0]});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N:0] fr;
    logic [N-1:0] held;
    void'($urandom(32'h5eed_1234));
    #1;
    // R1
    chk("R1", seg, '0);
    chk("R1", {{(N-1){1'b0}}, sdout}, '0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;

    // R2/R4: full direct frames with known bit order
    for (int f = 0; f < 6; f++) begin
      for (int i = 0; i <= N; i++) fr[i] = 1'($urandom);
      for (int i = 0; i <= N; i++) cyc(fr[i], 1'b0, 1'b1);
      chk("R2", {{(N-1){1'b0}}, sdout}, {{(N-1){1'b0}}, fr[0]});
      cyc(1'($urandom), 1'b1, 1'b1);
      chk("R4", seg, exp_seg(fr[N:1], 1'b1));
      // R5: chain cleared, zeros flow out
      for (int i = 0; i <= N; i++) begin
        cyc(1'b0, 1'b0, 1'b1);
        chk("R5", {{(N-1){1'b0}}, sdout}, '0);
      end
    end

    // R6/R8: random shifting with gate toggling, no loads
    held = seg;
    for (int i = 0; i < 80; i++) cyc(1'($urandom), 1'b0, ($urandom % 4) != 0);
    blank = 1'b1;
    #1;
    chk("R6", seg, held);

    // random-length direct loads, including over-long ones
    for (int f = 0; f < 20; f++) begin
      int len = 1 + ($urandom % 45);
      for (int i = 0; i < len; i++) cyc(1'($urandom), 1'b0, ($urandom % 4) != 0);
      cyc(1'($urandom), 1'b1, 1'b1);
    end

    // clear chain then self-load mode
    cyc(1'b0, 1'b1, 1'b1);
    loop = 1'b1;
    for (int f = 0; f < 10; f++) begin
      fr[0] = 1'b1;
      for (int i = 1; i <= N; i++) fr[i] = 1'($urandom);
      for (int g = 0; g < int'($urandom % 4); g++) cyc(1'b0, 1'b0, 1'b1);
      for (int i = 0; i <= N; i++) cyc(fr[i], 1'b0, 1'b1);
      cyc(1'($urandom), 1'b0, 1'b1);
      chk("R9", seg, exp_seg(fr[N:1], 1'b1));
    end
    // R10: long zero run must not reload
    held = seg;
    for (int i = 0; i < 3 * (N + 1); i++) cyc(1'b0, 1'b0, 1'b1);
    chk("R10", seg, held);

    // R8: gate low keeps latch, high restores it
    cyc(1'b0, 1'b0, 1'b0);
    chk("R8", seg, '0);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R8", seg, held);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule